// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplexer

This block holds an eight-bit word, and every bit of the word drives its own output pin at all times. A single data input writes one bit per clock. A three-bit address picks which bit is written. Two active-low controls select what happens at each rising clock edge:

- an addressed bit write;
- a hold;
- a decode, in which only the addressed output can be high;
- a clear of the whole word.

Software or a sequencer can use the block in two ways. It can shift a word in one bit at a time, writing successive addresses, and read the result in parallel. It can also use the decode mode to steer one pulse onto one of eight lines.

All state sits in edge-triggered registers. A control, address or data change between clock edges has no effect until the next rising edge. An asynchronous active-low reset clears the word. The release of that reset passes through a synchronizer inside the block.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low, `q_o` is 8'h00. It stays 8'h00 until a non-hold mode is applied after the release.
- R2: With `en_n`=0 and `clr_n`=1 (write mode), a rising edge sets bit `addr_i` of `q_o` to `din_i`. The other seven bits keep their values.
- R3: With `en_n`=1 and `clr_n`=1 (hold mode), a rising edge leaves all eight bits unchanged, whatever `addr_i` and `din_i` are.
- R4: With `en_n`=0 and `clr_n`=0 (decode mode), after a rising edge bit `addr_i` equals `din_i` and every other bit is 0.
- R5: With `en_n`=1 and `clr_n`=0 (clear mode), after a rising edge `q_o` is 8'h00, whatever `addr_i` and `din_i` are.
- R6: Address value k selects output bit `q_o[k]`. Address 0 selects the least significant bit and address 7 the most significant bit.
- R7: Eight write-mode cycles to addresses 0 through 7, carrying the bits of a word, leave that word on `q_o`.
- R8: The pattern left by a decode cycle remains on `q_o` through the hold cycles that follow.
- R9: `q_o` changes only at a rising clock edge. Between edges it keeps the value from the last edge, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| en_n | input | 1 | Active-low enable; selects write or decode when low |
| clr_n | input | 1 | Active-low clear; selects decode or clear when low |
| addr_i | input | 3 | Bit address |
| din_i | input | 1 | Serial data bit |
| q_o | output | 8 | Stored word, one output per bit |

## Verification
Every mode's result is due one rising edge after the inputs are sampled. The bench therefore drives the inputs at a falling edge and compares `q_o` with its model at the next falling edge. Before that, a probe two nanoseconds after the drive confirms that the output still holds the previous edge's value. After the reset is released, `q_o` stays idle for two extra edges while the synchronizer settles, so the bench waits three cycles before it applies any stimulus.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } latch_mode_e;
endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic        en_n,
  input  logic        clr_n,
  output latch_mode_e mode_o
);
  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DECODE;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch_onehot.sv
module addr_latch_onehot #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NBITS-1:0]  sel_o
);
  for (genvar g = 0; g < NBITS; g++) begin : g_sel
    assign sel_o[g] = (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/addr_latch_store.sv
module addr_latch_store
  import addr_latch_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  latch_mode_e      mode_i,
  input  logic [NBITS-1:0] sel_i,
  input  logic             din_i,
  output logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] q_d;
  logic [NBITS-1:0] q_en;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    always_comb begin
      q_en[g] = 1'b0;
      q_d[g]  = q_o[g];
      unique case (mode_i)
        MODE_WRITE: begin
          q_en[g] = sel_i[g];
          q_d[g]  = din_i;
        end
        MODE_DECODE: begin
          q_en[g] = 1'b1;
          q_d[g]  = sel_i[g] & din_i;
        end
        MODE_CLEAR: begin
          q_en[g] = 1'b1;
          q_d[g]  = 1'b0;
        end
        default: begin
          q_en[g] = 1'b0;
          q_d[g]  = q_o[g];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[g] <= 1'b0;
      else if (q_en[g])  q_o[g] <= q_d[g];
    end
  end

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HOLD) |=> $stable(q_o));
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_CLEAR) |=> (q_o == '0));
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic [NBITS-1:0]  q_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  latch_mode_e            mode;
  logic [NBITS-1:0]       sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  addr_latch_mode_dec u_mode (
    .en_n   (en_n),
    .clr_n  (clr_n),
    .mode_o (mode)
  );

  addr_latch_onehot #(.ADDR_W(ADDR_W)) u_sel (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  addr_latch_store #(.NBITS(NBITS)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .mode_i (mode),
    .sel_i  (sel),
    .din_i  (din_i),
    .q_o    (q_o)
  );

  // R2 and R6: the addressed bit takes din, the other bits keep their values
  a_r2_write_bit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en_n && clr_n) |=> (q_o[$past(addr_i)] == $past(din_i)));
  a_r2_write_others: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en_n && clr_n) |=>
      (((q_o ^ $past(q_o)) & ~(NBITS'(1) << $past(addr_i))) == '0));
  // R4: after a decode edge, only the addressed bit may be high
  a_r4_decode: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en_n && !clr_n) |=>
      ((q_o & ~(NBITS'(1) << $past(addr_i))) == '0) &&
      (q_o[$past(addr_i)] == $past(din_i)));
  // R1: the word is clear while the reset is asserted
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (q_o == '0));
endmodule

// File: tb/addr_latch8_tb_top.sv
module addr_latch8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_n, clr_n, din_i;
  logic [2:0] addr_i;
  logic [7:0] q_o;
  logic [7:0] exp_q;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  addr_latch8 dut_i (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr_n(clr_n),
    .addr_i(addr_i), .din_i(din_i), .q_o(q_o)
  );

  function automatic logic [7:0] model_next(logic [7:0] q, logic e_n, logic c_n,
                                            logic [2:0] a, logic d);
    logic [7:0] r;
    r = q;
    case ({c_n, e_n})
      2'b10: r[a] = d;
      2'b11: r = q;
      2'b00: r = 8'(d) << a;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic string mode_tag(logic e_n, logic c_n);
    case ({c_n, e_n})
      2'b10:   return "R2/R6";
      2'b11:   return "R3";
      2'b00:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at a falling edge, probe between edges, check at the next falling edge
  task automatic step(logic e_n, logic c_n, logic [2:0] a, logic d, string tag);
    en_n = e_n; clr_n = c_n; addr_i = a; din_i = d;
    #2;
    check("R9 pre-edge", q_o, exp_q);
    @(posedge clk);
    exp_q = model_next(exp_q, e_n, c_n, a, d);
    @(negedge clk);
    check(tag, q_o, exp_q);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] word;
    rst_n = 1'b0; en_n = 1'b0; clr_n = 1'b1; addr_i = 3'd5; din_i = 1'b1;
    exp_q = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 during reset", q_o, 8'h00);
    rst_n = 1'b1; en_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", q_o, 8'h00);

    // R7: serial load of a word, LSB at address 0
    word = 8'hA6;
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(i), word[i], "R7 load");
    check("R7 word", q_o, 8'hA6);
    // R6 mapping: address 7 drives the MSB
    step(1'b0, 1'b1, 3'd7, 1'b0, "R6 msb");
    check("R6 msb", q_o, 8'h26);
    // back-to-back writes to the same address
    step(1'b0, 1'b1, 3'd3, 1'b1, "R2 same addr");
    step(1'b0, 1'b1, 3'd3, 1'b0, "R2 same addr");
    // hold with changing address and data
    step(1'b1, 1'b1, 3'd1, 1'b1, "R3 hold");
    step(1'b1, 1'b1, 3'd0, 1'b0, "R3 hold");
    // R8: decode then hold
    step(1'b0, 1'b0, 3'd4, 1'b1, "R4 decode");
    check("R8 decode pattern", q_o, 8'h10);
    step(1'b1, 1'b1, 3'd2, 1'b1, "R8 hold");
    step(1'b1, 1'b1, 3'd6, 1'b0, "R8 hold");
    check("R8 kept", q_o, 8'h10);
    step(1'b0, 1'b0, 3'd4, 1'b0, "R4 decode zero");
    // clear with data high
    step(1'b0, 1'b1, 3'd1, 1'b1, "R2 set");
    step(1'b1, 1'b0, 3'd1, 1'b1, "R5 clear");
    check("R5 clear", q_o, 8'h00);

    // random mix of all four modes
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      logic e_n, c_n;
      logic [2:0] a;
      logic d;
      int m;
      m = $urandom_range(0, 9);
      e_n = (m >= 6);
      c_n = !(m == 5 || m == 9);
      a = 3'($urandom_range(0, 7));
      d = 1'($urandom);
      step(e_n, c_n, a, d, mode_tag(e_n, c_n));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule